// File: doc/BRIEF.md
# Video Frame Writer Address Generator

This block sits between an incoming video pixel stream (AXI4-Stream video: `tuser` marks the first beat of a frame, `tlast` closes each line) and a memory write path. It turns every line into a write command made of a start address and a byte count. The line's data beats are forwarded one cycle later. Packed RGB frames use a single plane. Semi-planar 4:2:2 and 4:2:0 frames use independent luma and chroma base pointers, and for these a chroma command is issued alongside the luma command on every line that carries chroma.

Geometry and format (stride, width, height, format) live in a shadow copy, and the two plane pointers are also held inside the block. Both are loaded only when a frame is taken on, so programming the configuration inputs mid-frame affects only the next frame. The very first frame after start takes the programmed values at once. With continuous mode set, the block re-arms itself at every frame end using whatever is programmed at that moment, so an unchanged configuration keeps writing to the same buffer. A one-cycle pulse marks each completed frame. Two sticky flags report a rejected configuration and a line whose length disagrees with the programmed width.

Top module: `vfw_addrgen`

## Requirements
- R1: After reset `s_tready`, `ycmd_valid`, `ccmd_valid`, `wr_valid`, `frame_done`, `err_cfg` and `err_len` are all 0.
- R2: While idle, `cfg_start`=1 with a valid configuration makes the engine run from the next cycle (`s_tready`=1), and the programmed values apply to the first frame immediately.
- R3: Each line produces one luma command, valid the cycle after the line's first accepted beat, with address luma_base + row*stride and byte count width*3 for format 0 (packed RGB), or width for format 1 (semi-planar 4:2:2) and format 2 (semi-planar 4:2:0).
- R4: In format 1 every line also produces a chroma command in the same cycle as its luma command, at chroma_base + row*stride, with byte count width.
- R5: In format 2 only even rows produce a chroma command, at chroma_base + (row/2)*stride, with byte count width. Format 0 produces no chroma commands.
- R6: Changes to the configuration inputs during a frame do not affect that frame's commands. They apply from the next frame.
- R7: At a frame end with `cfg_auto`=1, the next frame starts with the currently programmed values, so an unchanged configuration reuses the same addresses. With `cfg_auto`=0 the engine goes idle (`s_tready`=0).
- R8: `frame_done` is a single-cycle pulse, high in the cycle after the `tlast` of row height-1 is accepted.
- R9: A start or reload is rejected and `err_cfg` is set (sticky until reset, engine idle) if the luma address, or for formats 1 and 2 the chroma address, is not a multiple of 8*PPC; if width or height is below 64; if width is not a multiple of PPC; or if format is 3.
- R10: A `tlast` on a beat count other than width/PPC sets the sticky `err_len`. The line is still closed there, and the next row's address advances by one stride.
- R11: While running but waiting for a frame, beats without `tuser` are dropped: no data beat and no command result.
- R12: Every accepted beat appears on `wr_data`/`wr_last` with `wr_valid` one cycle later, with unchanged data and last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_luma_addr | input | 32 | Luma (or packed) plane base address |
| cfg_chroma_addr | input | 32 | Chroma plane base address |
| cfg_stride | input | 16 | Bytes between starts of consecutive rows |
| cfg_width | input | 14 | Active pixels per line |
| cfg_height | input | 14 | Lines per frame |
| cfg_fmt | input | 2 | 0 packed RGB, 1 semi-planar 4:2:2, 2 semi-planar 4:2:0, 3 invalid |
| cfg_start | input | 1 | Start request, sampled while idle |
| cfg_auto | input | 1 | Continuous re-arm at frame end |
| s_tdata | input | PPC*PIX_W | Pixel data |
| s_tvalid | input | 1 | Beat valid |
| s_tuser | input | 1 | First beat of frame |
| s_tlast | input | 1 | Last beat of line |
| s_tready | output | 1 | Engine running and accepting |
| wr_valid | output | 1 | Forwarded data beat valid |
| wr_data | output | PPC*PIX_W | Forwarded data |
| wr_last | output | 1 | Forwarded last-of-line |
| ycmd_valid | output | 1 | Luma line command valid |
| ycmd_addr | output | 32 | Luma line start address |
| ycmd_bytes | output | 16 | Luma line byte count |
| ccmd_valid | output | 1 | Chroma line command valid |
| ccmd_addr | output | 32 | Chroma line start address |
| ccmd_bytes | output | 16 | Chroma line byte count |
| frame_done | output | 1 | Frame complete pulse |
| err_cfg | output | 1 | Sticky configuration error |
| err_len | output | 1 | Sticky line length error |

## Verification
The bench changes the base addresses in the middle of a frame. A design that applied them at once would show the new base partway through that frame's luma commands. It runs 4:2:0 frames with odd heights, where a wrong row parity or a chroma pointer that advanced on every line would place chroma rows at double spacing or produce one command too many. A line shortened by two beats checks that the row is still closed, because a design that waited for the full width would merge two lines and shift every later address. Misaligned chroma, undersized width and the reserved format are each expected to leave the engine idle.

// File: rtl/vfw_pkg.sv
package vfw_pkg;

    localparam int ADDR_W   = 32;
    localparam int DIM_W    = 14;
    localparam int STRIDE_W = 16;
    localparam int MIN_DIM  = 64;

    typedef enum logic [1:0] {
        FMT_RGB   = 2'd0,
        FMT_SP422 = 2'd1,
        FMT_SP420 = 2'd2,
        FMT_RSVD  = 2'd3
    } vfw_fmt_e;

    typedef struct packed {
        logic [STRIDE_W-1:0] stride;
        logic [DIM_W-1:0]    width;
        logic [DIM_W-1:0]    height;
        vfw_fmt_e            fmt;
    } vfw_shape_t;

    function automatic logic is_semi(vfw_fmt_e f);
        return (f == FMT_SP422) || (f == FMT_SP420);
    endfunction

    function automatic logic [STRIDE_W-1:0] luma_bytes(vfw_fmt_e f, logic [DIM_W-1:0] w);
        return (f == FMT_RGB) ? STRIDE_W'(w) * STRIDE_W'(3) : STRIDE_W'(w);
    endfunction

    function automatic logic cfg_ok(vfw_shape_t s, logic [ADDR_W-1:0] ya,
                                    logic [ADDR_W-1:0] ca, int unsigned ppc);
        logic [ADDR_W-1:0] amask;
        logic [DIM_W-1:0]  pmask;
        amask = ADDR_W'(8 * ppc - 1);
        pmask = DIM_W'(ppc - 1);
        return (s.fmt != FMT_RSVD)
            && (s.width  >= DIM_W'(MIN_DIM))
            && (s.height >= DIM_W'(MIN_DIM))
            && ((s.width & pmask) == '0)
            && ((ya & amask) == '0)
            && (!is_semi(s.fmt) || ((ca & amask) == '0));
    endfunction

endpackage

// File: rtl/vfw_shadow.sv
module vfw_shadow
    import vfw_pkg::*;
#(
    parameter int PPC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  vfw_shape_t        shape_in,
    input  logic [ADDR_W-1:0] luma_in,
    input  logic [ADDR_W-1:0] chroma_in,
    input  logic              start,
    input  logic              auto_en,
    input  logic              frame_end,
    output vfw_shape_t        act,
    output logic              run,
    output logic              take,
    output logic              err_cfg
);
    logic ok;
    assign ok = cfg_ok(shape_in, luma_in, chroma_in, PPC);

    // take: shadow and plane pointers load on this edge
    assign take = (!run && start && !err_cfg && ok) || (run && frame_end && auto_en && ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= '0;
            run     <= 1'b0;
            err_cfg <= 1'b0;
        end else begin
            if (take) begin
                act <= shape_in;
                run <= 1'b1;
            end else if (!run && start && !err_cfg) begin
                err_cfg <= 1'b1;
            end else if (run && frame_end) begin
                run <= 1'b0;
                if (auto_en) err_cfg <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vfw_line_track.sv
module vfw_line_track
    import vfw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             take,
    input  logic             s_tvalid,
    input  logic             s_tuser,
    input  logic             s_tlast,
    input  logic [DIM_W-1:0] exp_beats,
    input  logic [DIM_W-1:0] height,
    output logic             accept,
    output logic             line_first,
    output logic             line_end,
    output logic             frame_end,
    output logic             row_odd,
    output logic             err_len
);
    logic             in_frame;
    logic [DIM_W-1:0] beat_cnt;
    logic [DIM_W-1:0] row;

    assign accept     = run && s_tvalid && (in_frame || s_tuser);
    assign line_first = accept && (beat_cnt == '0);
    assign line_end   = accept && s_tlast;
    assign frame_end  = line_end && (row == height - DIM_W'(1));
    assign row_odd    = row[0];

    always_ff @(posedge clk) begin
        if (rst || take || frame_end) begin
            in_frame <= 1'b0;
            beat_cnt <= '0;
            row      <= '0;
        end else if (accept) begin
            in_frame <= 1'b1;
            if (s_tlast) begin
                beat_cnt <= '0;
                row      <= row + DIM_W'(1);
            end else begin
                beat_cnt <= beat_cnt + DIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_len <= 1'b0;
        end else if (line_end && (beat_cnt + DIM_W'(1) != exp_beats)) begin
            err_len <= 1'b1;
        end
    end
endmodule

// File: rtl/vfw_addr_gen.sv
module vfw_addr_gen
    import vfw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [ADDR_W-1:0]   luma_in,
    input  logic [ADDR_W-1:0]   chroma_in,
    input  vfw_shape_t          act,
    input  logic                line_first,
    input  logic                line_end,
    input  logic                row_odd,
    output logic                ycmd_valid,
    output logic [ADDR_W-1:0]   ycmd_addr,
    output logic [STRIDE_W-1:0] ycmd_bytes,
    output logic                ccmd_valid,
    output logic [ADDR_W-1:0]   ccmd_addr,
    output logic [STRIDE_W-1:0] ccmd_bytes
);
    logic [ADDR_W-1:0] luma_ptr;
    logic [ADDR_W-1:0] chroma_ptr;
    logic              chroma_line;

    assign chroma_line = (act.fmt == FMT_SP422) || ((act.fmt == FMT_SP420) && !row_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            luma_ptr   <= '0;
            chroma_ptr <= '0;
        end else if (take) begin
            luma_ptr   <= luma_in;
            chroma_ptr <= chroma_in;
        end else if (line_end) begin
            luma_ptr <= luma_ptr + ADDR_W'(act.stride);
            if (chroma_line) chroma_ptr <= chroma_ptr + ADDR_W'(act.stride);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ycmd_valid <= 1'b0;
            ycmd_addr  <= '0;
            ycmd_bytes <= '0;
            ccmd_valid <= 1'b0;
            ccmd_addr  <= '0;
            ccmd_bytes <= '0;
        end else begin
            ycmd_valid <= line_first;
            ccmd_valid <= line_first && chroma_line;
            if (line_first) begin
                ycmd_addr  <= luma_ptr;
                ycmd_bytes <= luma_bytes(act.fmt, act.width);
                ccmd_addr  <= chroma_ptr;
                ccmd_bytes <= STRIDE_W'(act.width);
            end
        end
    end
endmodule

// File: rtl/vfw_addrgen.sv
module vfw_addrgen
    import vfw_pkg::*;
#(
    parameter int PPC   = 2,
    parameter int PIX_W = 24,
    localparam int DW   = PPC * PIX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_luma_addr,
    input  logic [ADDR_W-1:0]   cfg_chroma_addr,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic [1:0]          cfg_fmt,
    input  logic                cfg_start,
    input  logic                cfg_auto,
    input  logic [DW-1:0]       s_tdata,
    input  logic                s_tvalid,
    input  logic                s_tuser,
    input  logic                s_tlast,
    output logic                s_tready,
    output logic                wr_valid,
    output logic [DW-1:0]       wr_data,
    output logic                wr_last,
    output logic                ycmd_valid,
    output logic [ADDR_W-1:0]   ycmd_addr,
    output logic [STRIDE_W-1:0] ycmd_bytes,
    output logic                ccmd_valid,
    output logic [ADDR_W-1:0]   ccmd_addr,
    output logic [STRIDE_W-1:0] ccmd_bytes,
    output logic                frame_done,
    output logic                err_cfg,
    output logic                err_len
);
    localparam int PPC_SH = $clog2(PPC);

    vfw_shape_t shape_in, act;
    logic run, take, accept, line_first, line_end, frame_end, row_odd;

    assign shape_in = '{stride: cfg_stride, width: cfg_width,
                        height: cfg_height, fmt: vfw_fmt_e'(cfg_fmt)};
    assign s_tready = run;

    vfw_shadow #(.PPC(PPC)) u_shadow (
        .clk(clk), .rst(rst), .shape_in(shape_in), .luma_in(cfg_luma_addr),
        .chroma_in(cfg_chroma_addr), .start(cfg_start), .auto_en(cfg_auto),
        .frame_end(frame_end), .act(act), .run(run), .take(take), .err_cfg(err_cfg)
    );

    vfw_line_track u_track (
        .clk(clk), .rst(rst), .run(run), .take(take), .s_tvalid(s_tvalid),
        .s_tuser(s_tuser), .s_tlast(s_tlast), .exp_beats(act.width >> PPC_SH),
        .height(act.height), .accept(accept), .line_first(line_first),
        .line_end(line_end), .frame_end(frame_end), .row_odd(row_odd), .err_len(err_len)
    );

    vfw_addr_gen u_addr (
        .clk(clk), .rst(rst), .take(take), .luma_in(cfg_luma_addr),
        .chroma_in(cfg_chroma_addr), .act(act), .line_first(line_first),
        .line_end(line_end), .row_odd(row_odd), .ycmd_valid(ycmd_valid),
        .ycmd_addr(ycmd_addr), .ycmd_bytes(ycmd_bytes), .ccmd_valid(ccmd_valid),
        .ccmd_addr(ccmd_addr), .ccmd_bytes(ccmd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            wr_last    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            wr_valid   <= accept;
            frame_done <= frame_end;
            if (accept) begin
                wr_data <= s_tdata;
                wr_last <= s_tlast;
            end
        end
    end
endmodule

// File: rtl/vfw_addrgen_chk.sv
module vfw_addrgen_chk #(
    parameter int DW = 48
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] s_tdata,
    input logic          s_tvalid,
    input logic          s_tuser,
    input logic          s_tready,
    input logic          wr_valid,
    input logic [DW-1:0] wr_data,
    input logic          ycmd_valid,
    input logic          ccmd_valid,
    input logic          frame_done,
    input logic          err_cfg,
    input logic          err_len
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_cfg_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_cfg |=> err_cfg);

    p_cfg_idle_r9: assert property (@(posedge clk) disable iff (rst)
        err_cfg |-> !s_tready);

    p_len_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_len |=> err_len);

    p_ccmd_pair_r4: assert property (@(posedge clk) disable iff (rst)
        ccmd_valid |-> ycmd_valid);

    p_wr_follow_r12: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && s_tuser) |=> (wr_valid && wr_data == $past(s_tdata)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !s_tready |=> !wr_valid);
endmodule

bind vfw_addrgen vfw_addrgen_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tuser(s_tuser),
    .s_tready(s_tready), .wr_valid(wr_valid), .wr_data(wr_data),
    .ycmd_valid(ycmd_valid), .ccmd_valid(ccmd_valid), .frame_done(frame_done),
    .err_cfg(err_cfg), .err_len(err_len)
);

// File: tb/sim_vfw_addrgen.sv
module sim_vfw_addrgen;
    localparam int PPC = 2;
    localparam int PIX_W = 24;
    localparam int DW = PPC * PIX_W;

    logic clk = 0, rst = 1;
    logic [31:0] cfg_luma_addr = 0, cfg_chroma_addr = 0;
    logic [15:0] cfg_stride = 0;
    logic [13:0] cfg_width = 0, cfg_height = 0;
    logic [1:0]  cfg_fmt = 0;
    logic cfg_start = 0, cfg_auto = 0;
    logic [DW-1:0] s_tdata = 0;
    logic s_tvalid = 0, s_tuser = 0, s_tlast = 0;
    logic s_tready, wr_valid, wr_last, ycmd_valid, ccmd_valid, frame_done, err_cfg, err_len;
    logic [DW-1:0] wr_data;
    logic [31:0] ycmd_addr, ccmd_addr;
    logic [15:0] ycmd_bytes, ccmd_bytes;

    vfw_addrgen #(.PPC(PPC), .PIX_W(PIX_W)) u0 (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    longint ya[$], yb[$], ca[$], cb[$];
    logic [DW-1:0] dq[$];
    int done_n = 0, wr_n = 0, wr_bad = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ycmd_valid) begin ya.push_back(ycmd_addr); yb.push_back(ycmd_bytes); end
            if (ccmd_valid) begin ca.push_back(ccmd_addr); cb.push_back(ccmd_bytes); end
            if (frame_done) done_n++;
            if (wr_valid) begin
                wr_n++;
                if (dq.size() == 0) wr_bad++;
                else if (dq.pop_front() != wr_data) wr_bad++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic do_reset();
        rst = 1; cfg_start = 0; s_tvalid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic clear_obs();
        ya.delete(); yb.delete(); ca.delete(); cb.delete(); dq.delete();
        done_n = 0; wr_n = 0; wr_bad = 0;
    endtask

    task automatic set_cfg(int fmt, int w, int h, longint luma, longint chroma, int stride);
        cfg_fmt = 2'(fmt); cfg_width = 14'(w); cfg_height = 14'(h);
        cfg_luma_addr = 32'(luma); cfg_chroma_addr = 32'(chroma); cfg_stride = 16'(stride);
    endtask

    task automatic send_frame(int h, int beats, int short_row);
        for (int r = 0; r < h; r++) begin
            int n;
            n = (r == short_row) ? beats - 2 : beats;
            for (int b = 0; b < n; b++) begin
                if ($urandom % 4 == 0) begin s_tvalid = 0; @(negedge clk); end
                s_tvalid = 1; s_tuser = (r == 0 && b == 0); s_tlast = (b == n - 1);
                s_tdata = DW'({$urandom, $urandom});
                dq.push_back(s_tdata);
                @(negedge clk);
            end
        end
        s_tvalid = 0; s_tuser = 0; s_tlast = 0;
        repeat (3) @(negedge clk);
    endtask

    // expected commands from R3 / R4 / R5
    task automatic check_frame(int fmt, int w, int h, longint luma, longint chroma, int stride, string tag);
        int bad, nc;
        bad = 0;
        chk(ya.size() == h, {tag, " R3 luma cmd count"}, ya.size(), h);
        for (int i = 0; i < ya.size() && i < h; i++)
            if (ya[i] != ((luma + longint'(i) * stride) & 64'hFFFF_FFFF) ||
                yb[i] != ((fmt == 0) ? w * 3 : w)) bad++;
        chk(bad == 0, {tag, " R3 luma addr/bytes"}, bad, 0);
        nc = (fmt == 0) ? 0 : (fmt == 1) ? h : (h + 1) / 2;
        chk(ca.size() == nc, {tag, (fmt == 2) ? " R5 chroma count" : " R4 chroma count"}, ca.size(), nc);
        bad = 0;
        for (int i = 0; i < ca.size() && i < nc; i++)
            if (ca[i] != ((chroma + longint'(i) * stride) & 64'hFFFF_FFFF) || cb[i] != w) bad++;
        chk(bad == 0, {tag, " R4/R5 chroma addr/bytes"}, bad, 0);
        chk(done_n == 1, {tag, " R8 done pulses"}, done_n, 1);
    endtask

    initial begin
        int w, h, fmt, stride, sr;
        longint l1, c1, l2, c2;
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk(s_tready == 0 && ycmd_valid == 0 && ccmd_valid == 0 && wr_valid == 0,
            "R1 outputs idle", s_tready, 0);
        chk(err_cfg == 0 && err_len == 0 && frame_done == 0, "R1 flags clear", err_cfg, 0);

        // R2 first frame, R11 strays, R12 data, R7 idle afterwards
        set_cfg(0, 64, 64, 32'h1000, 0, 256);
        cfg_auto = 0; cfg_start = 1;
        @(negedge clk);
        chk(s_tready == 1, "R2 running after start", s_tready, 1);
        cfg_start = 0;
        clear_obs();
        for (int i = 0; i < 3; i++) begin
            s_tvalid = 1; s_tuser = 0; s_tlast = 0; s_tdata = DW'(i); @(negedge clk);
        end
        s_tvalid = 0; repeat (2) @(negedge clk);
        chk(wr_n == 0 && ya.size() == 0, "R11 stray beats dropped", wr_n, 0);
        send_frame(64, 32, -1);
        check_frame(0, 64, 64, 32'h1000, 0, 256, "directed RGB");
        chk(wr_n == 64 * 32 && wr_bad == 0, "R12 forwarded beats", wr_bad, 0);
        chk(err_len == 0, "R10 no length error on good frame", err_len, 0);
        chk(s_tready == 0, "R7 idle without continuous mode", s_tready, 0);

        // random frames over the three formats
        for (int it = 0; it < 4; it++) begin
            fmt = it % 3;
            w = 64 + PPC * int'($urandom % 33);
            h = 64 + int'($urandom % 7);
            stride = ((fmt == 0) ? w * 3 : w) + int'($urandom % 64);
            l1 = longint'($urandom & 32'h00FF_FFF0);
            c1 = longint'($urandom & 32'h00FF_FFF0) | 32'h0100_0000;
            set_cfg(fmt, w, h, l1, c1, stride);
            cfg_auto = 0; cfg_start = 1; @(negedge clk); cfg_start = 0;
            clear_obs();
            send_frame(h, w / PPC, -1);
            check_frame(fmt, w, h, l1, c1, stride, "random");
            chk(wr_bad == 0, "R12 random data", wr_bad, 0);
        end

        // R6 shadowing and R7 continuous reuse, 4:2:0 with odd height
        w = 96; h = 65; stride = 128;
        l1 = 32'h2000_0000; c1 = 32'h2100_0000; l2 = 32'h3000_0000; c2 = 32'h3100_0000;
        set_cfg(2, w, h, l1, c1, stride);
        cfg_auto = 1; cfg_start = 1; @(negedge clk); cfg_start = 0;
        clear_obs();
        fork
            send_frame(h, w / PPC, -1);
            begin repeat (300) @(negedge clk); cfg_luma_addr = 32'(l2); cfg_chroma_addr = 32'(c2); end
        join
        check_frame(2, w, h, l1, c1, stride, "R6 frame during change");
        clear_obs();
        send_frame(h, w / PPC, -1);
        check_frame(2, w, h, l2, c2, stride, "R6 next frame new base");
        clear_obs();
        send_frame(h, w / PPC, -1);
        check_frame(2, w, h, l2, c2, stride, "R7 reuse unchanged");
        cfg_auto = 0;
        clear_obs();
        send_frame(h, w / PPC, -1);
        chk(s_tready == 0, "R7 stop after continuous cleared", s_tready, 0);

        // R10 short line
        do_reset();
        set_cfg(1, 64, 64, 32'h4000, 32'h8000, 80);
        cfg_auto = 0; cfg_start = 1; @(negedge clk); cfg_start = 0;
        clear_obs();
        sr = 5;
        send_frame(64, 32, sr);
        chk(err_len == 1, "R10 length error set", err_len, 1);
        check_frame(1, 64, 64, 32'h4000, 32'h8000, 80, "R10 line closed at tlast");

        // R9 configuration errors
        do_reset();
        set_cfg(1, 64, 64, 32'h4000, 32'h8004, 80);
        cfg_start = 1; repeat (3) @(negedge clk); cfg_start = 0;
        chk(err_cfg == 1 && s_tready == 0, "R9 misaligned chroma", err_cfg, 1);
        do_reset();
        set_cfg(0, 62, 64, 32'h4000, 0, 200);
        cfg_start = 1; repeat (3) @(negedge clk); cfg_start = 0;
        chk(err_cfg == 1 && s_tready == 0, "R9 width below minimum", err_cfg, 1);
        do_reset();
        set_cfg(3, 64, 64, 32'h4000, 0, 200);
        cfg_start = 1; repeat (3) @(negedge clk); cfg_start = 0;
        chk(err_cfg == 1 && s_tready == 0, "R9 reserved format", err_cfg, 1);
        do_reset();
        set_cfg(0, 64, 64, 32'h4010, 32'h0004, 200);
        cfg_start = 1; repeat (2) @(negedge clk); cfg_start = 0;
        chk(err_cfg == 0 && s_tready == 1, "R9 chroma unchecked for packed", err_cfg, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule